// File: doc/BRIEF.md
# Transmit Buffer Abort Controller

This block keeps track of three CAN transmit message buffers and handles the abort handshake between a host CPU and a transmit engine. It stores no frame data. For each buffer it holds an empty flag, an abort-request bit and an abort-acknowledge flag. The engine reports, per buffer, when a frame starts, completes, loses arbitration or ends in an error. The host reaches the block through two 8-bit registers, a flag register and a control register. It schedules a buffer by writing 1 to that buffer's empty flag. It asks for an abort by setting the buffer's request bit.

Each buffer runs its own state machine with three states. `SLOT_FREE` means the buffer is empty. `SLOT_QUEUED` means the buffer is loaded and not yet on the bus. `SLOT_SENDING` means the frame is on the bus. The transitions are:
- *schedule*: FREE to QUEUED, on a host write of 1 to the empty flag.
- *start*: QUEUED to SENDING, on the engine's start pulse.
- *grant*: QUEUED to FREE, when an abort request is pending.
- *complete*: SENDING to FREE, on success.
- *fail-abort*: SENDING to FREE, on lost arbitration or error while an abort request is pending.
- *retry*: SENDING to QUEUED, on lost arbitration or error with no request pending.
- *soft reset*: any state to FREE.

The interrupt request is high while any buffer is empty and has its interrupt enabled.

Top module: `txab_top`

## Requirements
- R1: After reset the flag register reads 0x07, with all buffers empty and all acknowledge flags clear. The control register reads 0x00 and `irq` is 0.
- R2: In the flag register, bits 2..0 are the empty flags and bits 5..3 are the acknowledge flags. Writing 1 to an empty flag schedules the buffer: from the next cycle its empty flag and acknowledge flag read 0. Writing 0 has no effect.
- R3: A request set on a queued buffer that has not started is granted one cycle after the request bit becomes visible. The empty flag and the acknowledge flag then both read 1.
- R4: A request set while the buffer is sending stays pending. The buffer stays non-empty until the frame ends. On success the buffer becomes empty with acknowledge 0. On lost arbitration or on error it becomes empty with acknowledge 1.
- R5: Lost arbitration or an error with no request pending returns the buffer to queued: the empty flag stays 0 and the buffer can start again.
- R6: A successful completion sets the empty flag and leaves the acknowledge flag at 0.
- R7: In the control register, bits 2..0 are the abort-request bits. Whenever a buffer's empty flag becomes 1, its request bit is cleared.
- R8: An abort-request write to a buffer that is already empty is ignored: the request bit reads 0.
- R9: In the control register, bits 6..4 are the interrupt enables. `irq` equals the OR over the buffers of (empty flag AND enable).
- R10: While `soft_rst` is 1 the flag register is held at 0x07 and schedule writes are ignored. The interrupt enables keep their value.
- R11: Unimplemented register bits (flag bits 7..6, control bits 7 and 3) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Holds the flag state in its reset value |
| reg_wr | input | 1 | Host write strobe |
| reg_wsel | input | 1 | Write target: 0 flag register, 1 control register |
| reg_wdata | input | 8 | Host write data |
| reg_rsel | input | 1 | Read select: 0 flag register, 1 control register |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| eng_start | input | 3 | Per-buffer pulse: frame transmission begins |
| eng_done | input | 3 | Per-buffer pulse: frame sent successfully |
| eng_lost | input | 3 | Per-buffer pulse: arbitration lost |
| eng_err | input | 3 | Per-buffer pulse: transmission error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine behaves correctly. It pulses `eng_start` only for a buffer that is queued, and it pulses done, lost or error only for a buffer that is sending, with at most one of the three in a cycle. The bench keeps to this by following every buffer through the same sequence a real engine would use: a start pulse after scheduling, and then exactly one ending pulse. It never overlaps a start with the cycle in which a request bit first becomes visible, because that cycle is the start-versus-grant race, and the bench does not drive it.

// File: rtl/txab_pkg.sv
package txab_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE    = 2'd0,
        SLOT_QUEUED  = 2'd1,
        SLOT_SENDING = 2'd2
    } slot_state_t;

    // register layout (host-visible field positions)
    localparam int REG_W      = 8;
    localparam int FLG_EMPTY  = 0;   // empty flags start here
    localparam int CTL_REQ    = 0;   // abort requests start here
    localparam int CTL_IE     = 4;   // interrupt enables start here
endpackage

// File: rtl/txab_slot.sv
module txab_slot
    import txab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic sched_wr,
    input  logic abreq_wr,
    input  logic ev_start,
    input  logic ev_done,
    input  logic ev_fail,
    output logic empty,
    output logic ack,
    output logic abreq
);
    slot_state_t state_q, state_d;
    logic        grant;
    logic        ack_q, abreq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        if (soft_rst) begin
            state_d = SLOT_FREE;
        end else begin
            unique case (state_q)
                SLOT_FREE: begin
                    if (sched_wr) state_d = SLOT_QUEUED;
                end
                SLOT_QUEUED: begin
                    if (ev_start) begin
                        state_d = SLOT_SENDING;
                    end else if (abreq_q) begin
                        state_d = SLOT_FREE;
                        grant   = 1'b1;
                    end
                end
                SLOT_SENDING: begin
                    if (ev_done) begin
                        state_d = SLOT_FREE;
                    end else if (ev_fail) begin
                        if (abreq_q) begin
                            state_d = SLOT_FREE;
                            grant   = 1'b1;
                        end else begin
                            state_d = SLOT_QUEUED;
                        end
                    end
                end
                default: state_d = SLOT_FREE;
            endcase
        end
    end

    // outputs: acknowledge and request bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            abreq_q <= 1'b0;
        end else begin
            if (soft_rst)
                ack_q <= 1'b0;
            else if (grant)
                ack_q <= 1'b1;
            else if (state_q == SLOT_FREE && state_d == SLOT_QUEUED)
                ack_q <= 1'b0;

            if (state_d == SLOT_FREE)
                abreq_q <= 1'b0;
            else if (abreq_wr)
                abreq_q <= 1'b1;
        end
    end

    assign empty = (state_q == SLOT_FREE);
    assign ack   = ack_q;
    assign abreq = abreq_q;

    // R2
    sched_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && sched_wr && !soft_rst) |=> (!empty && !ack));
    // R3
    queued_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_QUEUED && abreq && !ev_start && !soft_rst) |=> (empty && ack));
    // R4
    fail_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_SENDING && abreq && ev_fail && !ev_done && !soft_rst) |=> (empty && ack));
    // R5
    retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_SENDING && !abreq && ev_fail && !ev_done && !soft_rst) |=> !empty);
    // R6
    done_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_SENDING && ev_done && !soft_rst) |=> (empty && !ack));
    // R7
    empty_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !abreq);
    // R10
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (empty && !ack));
endmodule

// File: rtl/txab_ctrl.sv
module txab_ctrl
    import txab_pkg::*;
#(
    parameter int NBUF = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie_wr,
    input  logic [NBUF-1:0] ie_wdata,
    input  logic            rsel,
    input  logic [NBUF-1:0] empty,
    input  logic [NBUF-1:0] ack,
    input  logic [NBUF-1:0] abreq,
    output logic [REG_W-1:0] rdata,
    output logic            irq
);
    logic [NBUF-1:0] ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ie_q <= '0;
        else if (ie_wr) ie_q <= ie_wdata;
    end

    always_comb begin
        rdata = '0;
        if (rsel) begin
            rdata[CTL_REQ +: NBUF] = abreq;
            rdata[CTL_IE  +: NBUF] = ie_q;
        end else begin
            rdata[FLG_EMPTY +: NBUF]        = empty;
            rdata[FLG_EMPTY + NBUF +: NBUF] = ack;
        end
    end

    assign irq = |(empty & ie_q);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (empty != '0));
endmodule

// File: rtl/txab_top.sv
module txab_top
    import txab_pkg::*;
#(
    parameter int NBUF = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             reg_wr,
    input  logic             reg_wsel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rsel,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NBUF-1:0]  eng_start,
    input  logic [NBUF-1:0]  eng_done,
    input  logic [NBUF-1:0]  eng_lost,
    input  logic [NBUF-1:0]  eng_err,
    output logic             irq
);
    logic [NBUF-1:0] empty, ack, abreq;
    logic            flg_wr, ctl_wr;

    assign flg_wr = reg_wr && !reg_wsel;
    assign ctl_wr = reg_wr &&  reg_wsel;

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        txab_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .sched_wr (flg_wr && reg_wdata[FLG_EMPTY + i]),
            .abreq_wr (ctl_wr && reg_wdata[CTL_REQ + i]),
            .ev_start (eng_start[i]),
            .ev_done  (eng_done[i]),
            .ev_fail  (eng_lost[i] | eng_err[i]),
            .empty    (empty[i]),
            .ack      (ack[i]),
            .abreq    (abreq[i])
        );
    end

    txab_ctrl #(.NBUF(NBUF)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie_wr    (ctl_wr),
        .ie_wdata (reg_wdata[CTL_IE +: NBUF]),
        .rsel     (reg_rsel),
        .empty    (empty),
        .ack      (ack),
        .abreq    (abreq),
        .rdata    (reg_rdata),
        .irq      (irq)
    );
endmodule

// File: tb/txab_top_tb.sv
module txab_top_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       soft_rst = 0;
    logic       reg_wr = 0;
    logic       reg_wsel = 0;
    logic [7:0] reg_wdata = 0;
    logic       reg_rsel = 0;
    logic [7:0] reg_rdata;
    logic [2:0] eng_start = 0, eng_done = 0, eng_lost = 0, eng_err = 0;
    logic       irq;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    txab_top u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_done(eng_done),
        .eng_lost(eng_lost), .eng_err(eng_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_rsel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1; reg_wsel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
    endtask

    // kind: 0 start, 1 done, 2 lost, 3 err
    task automatic ev(input int kind, input logic [2:0] m);
        case (kind)
            0: eng_start = m;
            1: eng_done  = m;
            2: eng_lost  = m;
            default: eng_err = m;
        endcase
        @(negedge clk);
        eng_start = 0; eng_done = 0; eng_lost = 0; eng_err = 0;
    endtask

    task automatic sreset();
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 flags", v, 8'h07);
        rd(1, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 writing 0 has no effect; writing 1 schedules
        wr(0, 8'h00);
        rd(0, v); chk("R2 write0", v, 8'h07);
        wr(0, 8'h05);
        rd(0, v); chk("R2 sched", v, 8'h02);

        // per-buffer abort scenarios
        for (int b = 0; b < 3; b++) begin
            for (int sc = 0; sc < 5; sc++) begin
                logic [2:0] m;
                logic [7:0] oth;
                m = 3'b1 << b;
                oth = 8'h07 & ~{5'd0, m};
                sreset();
                wr(0, {5'd0, m});
                rd(0, v); chk("R2 sched one", v, oth);
                if (sc == 0) begin
                    wr(1, {5'd0, m});
                    rd(1, v); chk("R3 req visible", v, {5'd0, m});
                    rd(0, v); chk("R3 not yet granted", v, oth);
                    @(negedge clk);
                    rd(0, v); chk("R3 granted", v, 8'h07 | {2'd0, m, 3'd0});
                    rd(1, v); chk("R7 req cleared", v, 8'h00);
                    // R2 rescheduling clears ack
                    wr(0, {5'd0, m});
                    rd(0, v); chk("R2 resched clears ack", v, oth);
                end else if (sc < 4) begin
                    ev(0, m);
                    wr(1, {5'd0, m});
                    @(negedge clk);
                    rd(0, v); chk("R4 pending while sending", v, oth);
                    rd(1, v); chk("R4 req held", v, {5'd0, m});
                    ev(sc, m);
                    rd(0, v);
                    chk("R4 frame end", v, (sc == 1) ? 8'h07 : (8'h07 | {2'd0, m, 3'd0}));
                    rd(1, v); chk("R7 req cleared at end", v, 8'h00);
                end else begin
                    ev(0, m);
                    ev(2, m);
                    rd(0, v); chk("R5 lost retry", v, oth);
                    ev(0, m);
                    ev(3, m);
                    rd(0, v); chk("R5 err retry", v, oth);
                    ev(0, m);
                    ev(1, m);
                    rd(0, v); chk("R6 done no ack", v, 8'h07);
                end
            end
        end

        // R8 request on empty buffer ignored
        sreset();
        wr(1, 8'h07);
        rd(1, v); chk("R8 req on empty", v, 8'h00);

        // R11 unimplemented bits
        wr(0, 8'hFF);
        rd(0, v); chk("R11 flag hi bits", v, 8'h00);
        wr(1, 8'hFF);
        rd(1, v); chk("R11 ctrl bits", v, 8'h77);
        @(negedge clk);
        rd(0, v); chk("R11 flags after grant", v, 8'h3F);

        // R10 soft reset holds flags, keeps enables
        soft_rst = 1;
        reg_wr = 1; reg_wsel = 0; reg_wdata = 8'h07;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
        rd(0, v); chk("R10 held", v, 8'h07);
        @(negedge clk);
        rd(0, v); chk("R10 still held", v, 8'h07);
        soft_rst = 0;
        rd(1, v); chk("R10 enables kept", v, 8'h70);

        // R9 sweep over all empty patterns and enables
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 8; e++) begin
                logic exp_irq;
                sreset();
                wr(0, 8'(~p & 7));
                wr(1, 8'(e << 4));
                exp_irq = |(p[2:0] & e[2:0]);
                chk("R9 irq", {7'd0, irq}, {7'd0, exp_irq});
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule